// File: doc/BRIEF.md
# Dual-Channel Half-Band 2x Interpolator

This block raises the sample rate of a complex (I and Q) baseband stream by a factor of two ahead of a pair of converters. Each channel accepts a 10-bit two's complement sample whenever the shared input strobe is high. For every accepted sample it emits two output samples on the following two clock cycles. The clock runs at the output rate, so the strobe is high on at most every other cycle.

The filter is a 43-tap half-band low-pass. Every second tap is zero and the centre tap equals 2^14. The block splits it into two polyphase branches. The first output of each pair is a delayed copy of an earlier input. The second output is a symmetric sum of 11 coefficient pairs, rounded back to 10 bits and clipped. The I and Q channels use identical filters that share one strobe, so both channels have the same latency.

Top module: `dual_hb_interp`

## Requirements
- R1: While reset is asserted, and after its release, the outputs are zero, `out_valid` is low and every stored sample in both delay lines is zero.
- R2: An input accepted at clock edge k produces `out_valid`=1 with `out_phase`=0 after edge k+1, and `out_valid`=1 with `out_phase`=1 after edge k+2. Inputs must be at least two cycles apart.
- R3: The phase-0 output for the m-th accepted sample equals, exactly, the sample accepted 11 strobes earlier (x[m-11]). This gives a group delay of 11 input periods.
- R4: The phase-1 output equals floor((S + 8192) / 16384), where S = sum over j=0..10 of c_j*(x[m-j] + x[m-21+j]) and c = 10, -31, 69, -138, 248, -419, 678, -1083, 1776, -3282, 10364 (j=0 first).
- R5: A phase-1 result above +511 is output as +511, and a result below -512 is output as -512.
- R6: Input and output words are 10-bit two's complement, with bit 9 as the sign (MSB) and bit 0 as the LSB.
- R7: The I and Q channels are filtered independently by the same arithmetic, and their results appear in the same cycle.
- R8: While `in_valid` is low, the delay lines do not advance, `out_valid` falls after any pending pair, and the outputs hold their last value.
- R9: A constant input held for at least 22 strobes is reproduced unchanged on both phases (unity DC gain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe shared by both channels |
| in_i | input | 10 | I-channel input sample |
| in_q | input | 10 | Q-channel input sample |
| out_valid | output | 1 | High when the outputs carry a new sample |
| out_phase | output | 1 | 0 for the delay-branch output, 1 for the FIR-branch output |
| out_i | output | 10 | I-channel output sample |
| out_q | output | 10 | Q-channel output sample |

## Verification
The delay-branch output for a sample is due one edge after the edge that captured it, and its FIR-branch output is due one edge later. The bench drives the strobe at a falling edge and drives the next sample at the second falling edge that follows. It reads the previous sample's phase-0 result at that drive edge and its phase-1 result at the falling edge in between, so every comparison falls half a period after the edge that produced the value. Before each comparison, the integer model has been advanced by exactly the samples the design has captured. Idle gaps and a mid-run reset are read at the same offsets.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int COEF_W = 16;   // signed coefficient width
    localparam int FRAC_W = 14;   // fractional bits of the unity gain

    // Non-zero side coefficients, outermost pair first
    function automatic int side_coef(input int j);
        case (j)
            0:       return 10;
            1:       return -31;
            2:       return 69;
            3:       return -138;
            4:       return 248;
            5:       return -419;
            6:       return 678;
            7:       return -1083;
            8:       return 1776;
            9:       return -3282;
            10:      return 10364;
            default: return 0;
        endcase
    endfunction

    typedef struct packed {
        logic ev;    // even phase due next edge
        logic od;    // odd phase due next edge
        logic vld;   // output strobe
        logic ph;    // output phase
    } seq_s;

endpackage

// File: rtl/hbi_phase_seq.sv
module hbi_phase_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic ld_even,
    output logic ld_odd,
    output logic out_valid,
    output logic out_phase
);
    import hbi_pkg::*;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.ev  = in_valid;
        seq_d.od  = seq_q.ev;
        seq_d.vld = seq_q.ev | seq_q.od;
        seq_d.ph  = seq_q.od;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ld_even   = seq_q.ev;
    assign ld_odd    = seq_q.od;
    assign out_valid = seq_q.vld;
    assign out_phase = seq_q.ph;

    // R2: even output two edges after the strobe is sampled
    a_r2_even_due: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_valid && !out_phase));
    // R2: odd output follows the even output
    a_r2_odd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_phase) |=> (out_valid && out_phase));
    // R2: input cadence of at least two cycles
    a_r2_cadence: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid);
    // R8: no strobe, no new even output
    a_r8_no_even: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !(out_valid && !out_phase));

endmodule

// File: rtl/hbi_lane.sv
module hbi_lane #(
    parameter int DATA_W = 10,
    parameter int NPAIR  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    input  logic              ld_even,
    input  logic              ld_odd,
    output logic [DATA_W-1:0] dout
);
    import hbi_pkg::*;

    localparam int DLINE  = 2 * NPAIR;
    localparam int CTR    = NPAIR;
    localparam int PAIR_W = DATA_W + 1;
    localparam int PROD_W = PAIR_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NPAIR) + 1;
    localparam int RND_W  = ACC_W - FRAC_W;
    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [RND_W-1:0] SMAX_R = RND_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [RND_W-1:0] SMIN_R = RND_W'(-(2 ** (DATA_W - 1)));

    typedef struct packed {
        logic [DLINE-1:0][DATA_W-1:0] x;
        logic [DATA_W-1:0]            hold;
        logic [DATA_W-1:0]            out;
    } lane_s;

    lane_s lane_d, lane_q;

    logic signed [PAIR_W-1:0] pair_w [NPAIR];
    logic signed [PROD_W-1:0] prod_w [NPAIR];
    logic signed [ACC_W-1:0]  acc_w;
    logic signed [ACC_W-1:0]  acc_rnd_w;
    logic signed [RND_W-1:0]  rnd_w;
    logic [DATA_W-1:0]        sat_w;

    // Symmetric branch: one multiplier per coefficient pair
    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
        localparam logic signed [COEF_W-1:0] CF = COEF_W'(side_coef(j));
        assign pair_w[j] = PAIR_W'($signed(lane_q.x[j]))
                         + PAIR_W'($signed(lane_q.x[DLINE-1-j]));
        assign prod_w[j] = pair_w[j] * CF;
    end

    always_comb begin
        acc_w = '0;
        for (int i = 0; i < NPAIR; i++) acc_w = acc_w + ACC_W'(prod_w[i]);
        acc_rnd_w = acc_w + HALF;
        rnd_w     = $signed(acc_rnd_w[ACC_W-1:FRAC_W]);
        if (rnd_w > SMAX_R)      sat_w = SMAX_R[DATA_W-1:0];
        else if (rnd_w < SMIN_R) sat_w = SMIN_R[DATA_W-1:0];
        else                     sat_w = rnd_w[DATA_W-1:0];
    end

    always_comb begin
        lane_d = lane_q;
        if (shift) begin
            lane_d.x[0] = din;
            for (int i = 1; i < DLINE; i++) lane_d.x[i] = lane_q.x[i-1];
        end
        if (ld_even) begin
            lane_d.out  = lane_q.x[CTR];
            lane_d.hold = sat_w;
        end else if (ld_odd) begin
            lane_d.out  = lane_q.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign dout = lane_q.out;

    // R5: a result above range shows up as the positive rail
    a_r5_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_even && (rnd_w > SMAX_R)) |-> ##2 ($signed(dout) == SMAX_R[DATA_W-1:0]));
    // R5: a result below range shows up as the negative rail
    a_r5_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_even && (rnd_w < SMIN_R)) |-> ##2 ($signed(dout) == SMIN_R[DATA_W-1:0]));
    // R8: output holds when no phase is loaded
    a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_even && !ld_odd) |=> $stable(dout));
    // R8: delay line frozen without a strobe
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(lane_q.x));

endmodule

// File: rtl/dual_hb_interp.sv
module dual_hb_interp #(
    parameter int DATA_W = 10,
    parameter int TAPS   = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_valid,
    output logic              out_phase,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);
    localparam int NPAIR = (TAPS + 1) / 4;
    localparam int NCH   = 2;

    logic              ld_even, ld_odd;
    logic [DATA_W-1:0] din_a  [NCH];
    logic [DATA_W-1:0] dout_a [NCH];

    assign din_a[0] = in_i;
    assign din_a[1] = in_q;

    hbi_phase_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ld_even   (ld_even),
        .ld_odd    (ld_odd),
        .out_valid (out_valid),
        .out_phase (out_phase)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        hbi_lane #(.DATA_W(DATA_W), .NPAIR(NPAIR)) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift   (in_valid),
            .din     (din_a[c]),
            .ld_even (ld_even),
            .ld_odd  (ld_odd),
            .dout    (dout_a[c])
        );
    end

    assign out_i = dout_a[0];
    assign out_q = dout_a[1];

    // R7: both channels change only on output strobes
    a_r7_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

// File: tb/test_dual_hb_interp.sv
module test_dual_hb_interp;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG = 7;
    // {i value, q value, count, alternate sign}
    localparam int SEG [NSEG][4] = '{
        '{511, -512, 1, 0},
        '{0, 0, 22, 0},
        '{-512, 511, 24, 0},
        '{511, -512, 24, 0},
        '{511, -512, 24, 1},
        '{100, -37, 24, 0},
        '{-300, 250, 6, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_i = '0, in_q = '0;
    logic       out_valid, out_phase;
    logic [9:0] out_i, out_q;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;
    int hi [22], hq [22];
    int pe_i, pe_q, po_i, po_q;
    string ptag_e, ptag_o;
    bit have_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_hb_interp i_dual_hb_interp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_phase(out_phase),
        .out_i(out_i), .out_q(out_q)
    );

    function automatic int cf(input int j);
        case (j)
            0: return 10;     1: return -31;   2: return 69;
            3: return -138;   4: return 248;   5: return -419;
            6: return 678;    7: return -1083; 8: return 1776;
            9: return -3282;  10: return 10364;
            default: return 0;
        endcase
    endfunction

    function automatic int odd_ref(input int h [22]);
        int acc = 0;
        int r;
        for (int j = 0; j < 11; j++) acc += cf(j) * (h[j] + h[21-j]);
        r = (acc + 8192) >>> 14;
        if (r > 511) r = 511;
        if (r < -512) r = -512;
        return r;
    endfunction

    function automatic bit flat(input int h [22]);
        for (int k = 1; k < 22; k++) if (h[k] != h[0]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_even();
        chk("R2", "even strobe", {31'd0, out_valid && !out_phase}, 1);
        chk(ptag_e, "even I", int'($signed(out_i)), pe_i);
        chk("R7", "even Q", int'($signed(out_q)), pe_q);
    endtask

    task automatic chk_odd();
        chk("R2", "odd strobe", {31'd0, out_valid && out_phase}, 1);
        chk(ptag_o, "odd I", int'($signed(out_i)), po_i);
        chk("R7", "odd Q", int'($signed(out_q)), po_q);
    endtask

    task automatic push(input int vi, input int vq, input string etag);
        int oi;
        @(negedge clk);
        if (have_prev) chk_even();
        in_valid = 1'b1;
        in_i = vi[9:0];
        in_q = vq[9:0];
        for (int k = 21; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
        hi[0] = vi;
        hq[0] = vq;
        @(negedge clk);
        in_valid = 1'b0;
        if (have_prev) chk_odd();
        pe_i = hi[11];
        pe_q = hq[11];
        oi = odd_ref(hi);
        po_i = oi;
        po_q = odd_ref(hq);
        ptag_e = etag;
        if (oi == 511 || oi == -512) ptag_o = flat(hi) ? "R9" : "R5";
        else ptag_o = flat(hi) ? "R9" : "R4";
        have_prev = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        chk_even();
        @(negedge clk);
        chk_odd();
        have_prev = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 22; k++) begin hi[k] = 0; hq[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid in reset", {31'd0, out_valid}, 0);
        chk("R1", "out_i in reset", int'($signed(out_i)), 0);
        chk("R1", "out_q in reset", int'($signed(out_q)), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", {31'd0, out_valid}, 0);

        // Table walk: impulse, steps, alternating extremes, DC (R3 R4 R5 R6 R9)
        for (int s = 0; s < NSEG; s++) begin
            for (int n = 0; n < SEG[s][2]; n++) begin
                int vi = SEG[s][0];
                int vq = SEG[s][1];
                if (SEG[s][3] != 0 && (n % 2) == 1) begin vi = -vi - 1; vq = -vq - 1; end
                push(vi, vq, (vi < 0 || vq < 0) ? "R6" : "R3");
            end
        end
        flush();

        // R8: idle gap, outputs hold, no strobe, history frozen
        repeat (4) begin
            @(negedge clk);
            chk("R8", "idle strobe", {31'd0, out_valid}, 0);
            chk("R8", "idle hold I", int'($signed(out_i)), po_i);
            chk("R8", "idle hold Q", int'($signed(out_q)), po_q);
        end
        push(-77, 333, "R8");
        push(12, -5, "R8");
        flush();

        // R1: mid-run reset clears history
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "out_i after mid reset", int'($signed(out_i)), 0);
        chk("R1", "out_valid after mid reset", {31'd0, out_valid}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 22; k++) begin hi[k] = 0; hq[k] = 0; end
        push(300, -300, "R1");
        flush();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule